// File: doc/BRIEF.md
# IO bank freeze/thaw sequencer

This block moves a set of general-purpose IO channels between a frozen state and a thawed (functional) state. Each channel has five pad controls: four active-low enables (slew, weak pull-up, tristate and bus-hold) and one active-high configuration-done flag. A one-cycle freeze or thaw request starts a fixed sequence. The sequence runs over the channels one at a time, lowest index first. The block waits a minimum number of clock cycles between dependent stages. That number is derived from a minimum time gap and the clock period.

Freezing takes two stages. First the slew, pull-up and tristate enables are asserted together. Later, bus-hold is asserted and configuration-done is cleared. Thawing takes three stages and groups the controls differently. First bus-hold is released and configuration-done is raised. Next the pull-up and tristate enables are released. The slew enable is released last. A per-channel status bit shows which channels are frozen, and a busy flag covers the whole sequence.

A source-select input decides who owns the pads. When it selects software, the pads come from this sequencer. Otherwise the pads follow a set of pass-through inputs from an external hardware controller.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every channel's slew_n, pull_n, tri_n and hold_n outputs are 0 and cfg_done is 0. All frozen_o bits are 1 and busy_o is 0.
- R2: A freeze request is accepted on a clock edge where sw_sel_i=1 and busy_o=0. On the next edge, channel 0's slew_n, pull_n and tri_n all go to 0 together.
- R3: The second freeze stage of a channel comes GAP cycles after its first stage. It drives hold_n to 0 and cfg_done to 0, and it sets that channel's frozen_o bit to 1 on the same edge. GAP is ceil(MIN_GAP_PS/CLK_PERIOD_PS), with a minimum of 1. The defaults give GAP=2.
- R4: The first thaw stage drives hold_n to 1 and cfg_done to 1. For channel 0 it comes one edge after the request is accepted.
- R5: The second thaw stage comes GAP cycles after the first. It drives pull_n and tri_n to 1 together.
- R6: The third thaw stage comes GAP cycles after the second. It drives slew_n to 1 and clears the channel's frozen_o bit on the same edge.
- R7: Channels run in ascending order. A channel's first stage comes GAP cycles after the previous channel's last stage. A frozen_o bit changes only on its own channel's last stage.
- R8: busy_o goes to 1 on the edge that accepts a request. It returns to 0 on the edge of the last stage. A request that arrives while busy_o=1 is ignored. If freeze and thaw are requested together, freeze wins.
- R9: With sw_sel_i=0, every pad output equals its hw_*_i input and requests are ignored: busy_o and frozen_o stay unchanged. With sw_sel_i=1, the pads show the sequencer's state again.
- R10: A freeze request when all channels are already frozen still runs the full 6 stages (busy_o=1 for 11 cycles). No pad output changes during that time, and frozen_o stays all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_sel_i | input | 1 | 1: sequencer owns pads and takes requests; 0: hardware pass-through |
| freeze_req_i | input | 1 | Freeze request |
| thaw_req_i | input | 1 | Thaw request |
| hw_slew_n_i | input | NUM_CH | Hardware controller slew enables |
| hw_pull_n_i | input | NUM_CH | Hardware controller weak pull-up enables |
| hw_tri_n_i | input | NUM_CH | Hardware controller tristate enables |
| hw_hold_n_i | input | NUM_CH | Hardware controller bus-hold enables |
| hw_cfg_done_i | input | NUM_CH | Hardware controller configuration-done flags |
| slew_n_o | output | NUM_CH | Slew enable per channel, active low |
| pull_n_o | output | NUM_CH | Weak pull-up enable per channel, active low |
| tri_n_o | output | NUM_CH | Tristate enable per channel, active low |
| hold_n_o | output | NUM_CH | Bus-hold enable per channel, active low |
| cfg_done_o | output | NUM_CH | Configuration-done per channel, active high |
| frozen_o | output | NUM_CH | Per-channel status, 1 = frozen |
| busy_o | output | 1 | Sequence in progress |

## Verification
On every cycle, the assertions check the ordering inside each channel. Bus-hold may only be asserted after the tristate enable was already low. Pull-up and tristate may only be released once bus-hold is released and configuration-done is high. Slew may only be released after the pull-up was released. Each status bit may only flip together with the control that ends its channel's sequence. The assertions also check that nothing moves while the block is idle, and that requests are ignored in hardware mode. Only the bench scenarios can show the exact cycle of each stage, the GAP spacing between stages, the ascending channel order and the dropping of a request made while busy.

// File: rtl/io_freeze_pkg.sv
package io_freeze_pkg;
  typedef enum logic {OP_FREEZE = 1'b0, OP_THAW = 1'b1} op_e;

  typedef struct packed {
    logic slew_n;
    logic pull_n;
    logic tri_n;
    logic hold_n;
    logic cfg_done;
  } pad_ctrl_t;

  localparam pad_ctrl_t PAD_FROZEN = '0;
  localparam int STEP_W = 2;
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= RELOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/chan_pad_seq.sv
module chan_pad_seq
  import io_freeze_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  output pad_ctrl_t         ctrl_o,
  output logic              frozen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= PAD_FROZEN;
      frozen_o <= 1'b1;
    end else if (fire_i) begin
      if (op_i == OP_FREEZE) begin
        case (step_i)
          2'd0: begin
            ctrl_o.slew_n <= 1'b0;
            ctrl_o.pull_n <= 1'b0;
            ctrl_o.tri_n  <= 1'b0;
          end
          2'd1: begin
            ctrl_o.hold_n   <= 1'b0;
            ctrl_o.cfg_done <= 1'b0;
            frozen_o        <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (step_i)
          2'd0: begin
            ctrl_o.hold_n   <= 1'b1;
            ctrl_o.cfg_done <= 1'b1;
          end
          2'd1: begin
            ctrl_o.pull_n <= 1'b1;
            ctrl_o.tri_n  <= 1'b1;
          end
          2'd2: begin
            ctrl_o.slew_n <= 1'b1;
            frozen_o      <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
  import io_freeze_pkg::*;
#(
  parameter int NUM_CH        = 3,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_GAP_PS    = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_sel_i,
  input  logic              freeze_req_i,
  input  logic              thaw_req_i,
  input  logic [NUM_CH-1:0] hw_slew_n_i,
  input  logic [NUM_CH-1:0] hw_pull_n_i,
  input  logic [NUM_CH-1:0] hw_tri_n_i,
  input  logic [NUM_CH-1:0] hw_hold_n_i,
  input  logic [NUM_CH-1:0] hw_cfg_done_i,
  output logic [NUM_CH-1:0] slew_n_o,
  output logic [NUM_CH-1:0] pull_n_o,
  output logic [NUM_CH-1:0] tri_n_o,
  output logic [NUM_CH-1:0] hold_n_o,
  output logic [NUM_CH-1:0] cfg_done_o,
  output logic [NUM_CH-1:0] frozen_o,
  output logic              busy_o
);
  localparam int GAP_RAW    = (MIN_GAP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              busy_q;
  op_e               op_q;
  logic [CH_W-1:0]   ch_q;
  logic [STEP_W-1:0] step_q;
  logic              gap_zero, fire, last_step, last_ch, accept;

  logic [NUM_CH-1:0] sw_slew_n, sw_pull_n, sw_tri_n, sw_hold_n, sw_cfg;

  assign accept    = !busy_q && sw_sel_i && (freeze_req_i || thaw_req_i);
  assign fire      = busy_q && gap_zero;
  assign last_step = (op_q == OP_THAW) ? (step_q == 2'd2) : (step_q == 2'd1);
  assign last_ch   = (ch_q == CH_W'(NUM_CH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_FREEZE;
      ch_q   <= '0;
      step_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= freeze_req_i ? OP_FREEZE : OP_THAW;
      ch_q   <= '0;
      step_q <= '0;
    end else if (fire) begin
      if (last_step) begin
        step_q <= '0;
        if (last_ch) busy_q <= 1'b0;
        else         ch_q   <= ch_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire && !(last_step && last_ch)),
    .zero_o (gap_zero)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pad_ctrl_t ctrl;

    chan_pad_seq i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fire_i   (fire && (ch_q == CH_W'(g))),
      .op_i     (op_q),
      .step_i   (step_q),
      .ctrl_o   (ctrl),
      .frozen_o (frozen_o[g])
    );

    assign sw_slew_n[g] = ctrl.slew_n;
    assign sw_pull_n[g] = ctrl.pull_n;
    assign sw_tri_n[g]  = ctrl.tri_n;
    assign sw_hold_n[g] = ctrl.hold_n;
    assign sw_cfg[g]    = ctrl.cfg_done;
  end

  // pad ownership
  assign slew_n_o   = sw_sel_i ? sw_slew_n : hw_slew_n_i;
  assign pull_n_o   = sw_sel_i ? sw_pull_n : hw_pull_n_i;
  assign tri_n_o    = sw_sel_i ? sw_tri_n  : hw_tri_n_i;
  assign hold_n_o   = sw_sel_i ? sw_hold_n : hw_hold_n_i;
  assign cfg_done_o = sw_sel_i ? sw_cfg    : hw_cfg_done_i;
  assign busy_o     = busy_q;
endmodule

// File: rtl/io_freeze_seq_chk.sv
module io_freeze_seq_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_sel_i,
  input logic              freeze_req_i,
  input logic              thaw_req_i,
  input logic [NUM_CH-1:0] sw_slew_n,
  input logic [NUM_CH-1:0] sw_pull_n,
  input logic [NUM_CH-1:0] sw_tri_n,
  input logic [NUM_CH-1:0] sw_hold_n,
  input logic [NUM_CH-1:0] sw_cfg,
  input logic [NUM_CH-1:0] frozen_o,
  input logic              busy_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2
    freeze_first_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_pull_n[g]) |-> !sw_slew_n[g] && !sw_tri_n[g]);
    // R3
    hold_after_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_hold_n[g]) |-> $past(!sw_tri_n[g]) && !sw_cfg[g] && frozen_o[g]);
    // R5
    release_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_pull_n[g]) |-> sw_tri_n[g] && $past(sw_hold_n[g]) && $past(sw_cfg[g]));
    // R6
    slew_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_slew_n[g]) |-> $past(sw_pull_n[g]) && $past(sw_tri_n[g]) && !frozen_o[g]);
    // R7
    thaw_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(frozen_o[g]) |-> $rose(sw_slew_n[g]));
    // R7
    freeze_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(frozen_o[g]) |-> !sw_hold_n[g] && !sw_cfg[g]);
  end

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sw_slew_n) && $stable(sw_pull_n) && $stable(sw_tri_n)
                && $stable(sw_hold_n) && $stable(sw_cfg) && $stable(frozen_o));
  // R8
  no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !freeze_req_i && !thaw_req_i) |=> !busy_o);
  // R9
  hw_mode_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sw_sel_i) |=> !busy_o);
endmodule

bind io_freeze_seq io_freeze_seq_chk #(.NUM_CH(NUM_CH)) i_io_freeze_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_sel_i     (sw_sel_i),
  .freeze_req_i (freeze_req_i),
  .thaw_req_i   (thaw_req_i),
  .sw_slew_n    (sw_slew_n),
  .sw_pull_n    (sw_pull_n),
  .sw_tri_n     (sw_tri_n),
  .sw_hold_n    (sw_hold_n),
  .sw_cfg       (sw_cfg),
  .frozen_o     (frozen_o),
  .busy_o       (busy_o)
);

// File: tb/test_io_freeze_seq.sv
`timescale 1ns/1ps
module test_io_freeze_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;

  localparam logic [4:0] FZ = 5'b00000;
  localparam logic [4:0] HB = 5'b00011;
  localparam logic [4:0] PT = 5'b01111;
  localparam logic [4:0] TH = 5'b11111;

  // {ch2, ch1, ch0, frozen[2:0], busy}; pad word = {slew_n,pull_n,tri_n,hold_n,cfg_done}
  localparam logic [18:0] VEC [15] = '{
    {FZ, FZ, HB, 3'b111, 1'b1},
    {FZ, FZ, PT, 3'b111, 1'b1},
    {FZ, FZ, TH, 3'b110, 1'b1},
    {FZ, HB, TH, 3'b110, 1'b1},
    {FZ, PT, TH, 3'b110, 1'b1},
    {FZ, TH, TH, 3'b100, 1'b1},
    {HB, TH, TH, 3'b100, 1'b1},
    {PT, TH, TH, 3'b100, 1'b1},
    {TH, TH, TH, 3'b000, 1'b0},
    {TH, TH, HB, 3'b000, 1'b1},
    {TH, TH, FZ, 3'b001, 1'b1},
    {TH, HB, FZ, 3'b001, 1'b1},
    {TH, FZ, FZ, 3'b011, 1'b1},
    {HB, FZ, FZ, 3'b011, 1'b1},
    {FZ, FZ, FZ, 3'b111, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_sel_i = 1'b1;
  logic freeze_req_i = 1'b0;
  logic thaw_req_i = 1'b0;
  logic [NUM_CH-1:0] hw_slew_n_i = '0, hw_pull_n_i = '0, hw_tri_n_i = '0;
  logic [NUM_CH-1:0] hw_hold_n_i = '0, hw_cfg_done_i = '0;
  logic [NUM_CH-1:0] slew_n_o, pull_n_o, tri_n_o, hold_n_o, cfg_done_o, frozen_o;
  logic busy_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_freeze_seq i_io_freeze_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sw_sel_i(sw_sel_i),
    .freeze_req_i(freeze_req_i), .thaw_req_i(thaw_req_i),
    .hw_slew_n_i(hw_slew_n_i), .hw_pull_n_i(hw_pull_n_i), .hw_tri_n_i(hw_tri_n_i),
    .hw_hold_n_i(hw_hold_n_i), .hw_cfg_done_i(hw_cfg_done_i),
    .slew_n_o(slew_n_o), .pull_n_o(pull_n_o), .tri_n_o(tri_n_o),
    .hold_n_o(hold_n_o), .cfg_done_o(cfg_done_o),
    .frozen_o(frozen_o), .busy_o(busy_o)
  );

  function automatic logic [18:0] observe();
    logic [18:0] v;
    for (int c = 0; c < NUM_CH; c++)
      v[4 + 5*c +: 5] = {slew_n_o[c], pull_n_o[c], tri_n_o[c], hold_n_o[c], cfg_done_o[c]};
    v[3:1] = frozen_o;
    v[0]   = busy_o;
    return v;
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  function automatic string tag(input int idx);
    if (idx < 9) begin
      case (idx % 3)
        0: return "R4";
        1: return "R5";
        default: return "R6 R7";
      endcase
    end else begin
      if ((idx - 9) % 2 == 0) return (idx == 9) ? "R2" : "R2 R7";
      return "R3 R7";
    end
  endfunction

  task automatic pulse(input bit frz);
    if (frz) freeze_req_i = 1'b1; else thaw_req_i = 1'b1;
    @(negedge clk);
    freeze_req_i = 1'b0;
    thaw_req_i   = 1'b0;
  endtask

  // walks table entries; starts one negedge after the accepting edge
  task automatic run_seq(input int first, input int count, input int inject_at);
    for (int k = 0; k < count; k++) begin
      if (k > 0) begin
        if (k == inject_at) freeze_req_i = 1'b1;
        @(negedge clk);
        freeze_req_i = 1'b0;
        check({tag(first + k), " gap"}, observe(), VEC[first + k - 1]);
      end
      @(negedge clk);
      check(tag(first + k), observe(), VEC[first + k]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 3000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check("R1", observe(), {FZ, FZ, FZ, 3'b111, 1'b0});

    // R10: freeze while all frozen: 11 busy cycles, pads never move
    pulse(1'b1);
    for (int i = 0; i < 11; i++) begin
      check("R10", observe(), {FZ, FZ, FZ, 3'b111, 1'b1});
      @(negedge clk);
    end
    check("R10", observe(), {FZ, FZ, FZ, 3'b111, 1'b0});

    // thaw walk with an ignored freeze request mid-sequence (R8)
    pulse(1'b0);
    check("R8", {18'b0, busy_o}, 19'd1);
    run_seq(0, 9, 5);
    @(negedge clk);
    check("R8", observe(), {TH, TH, TH, 3'b000, 1'b0});

    // freeze walk
    pulse(1'b1);
    run_seq(9, 6, -1);
    @(negedge clk);
    check("R8", observe(), {FZ, FZ, FZ, 3'b111, 1'b0});

    // R9: hardware ownership
    sw_sel_i      = 1'b0;
    hw_slew_n_i   = 3'b101;
    hw_pull_n_i   = 3'b011;
    hw_tri_n_i    = 3'b110;
    hw_hold_n_i   = 3'b001;
    hw_cfg_done_i = 3'b100;
    #1;
    check("R9", observe(), {5'b10101, 5'b01100, 5'b11010, 3'b111, 1'b0});
    @(negedge clk);
    pulse(1'b0);
    check("R9", {15'b0, frozen_o, busy_o}, {15'b0, 3'b111, 1'b0});
    repeat (20) @(negedge clk);
    check("R9", {15'b0, frozen_o, busy_o}, {15'b0, 3'b111, 1'b0});
    sw_sel_i = 1'b1;
    #1;
    check("R9", observe(), {FZ, FZ, FZ, 3'b111, 1'b0});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule